// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the operand fields of a load or store into the values the memory stage and the register writeback stage need. It takes a base register value, an unsigned offset magnitude with a subtract flag, an addressing mode and an access size. It then produces the access address, the address of the second word of a paired access, and the updated base value. It also reports whether the base should actually be written back.

The same request is screened for illegal offsets, which depend on both the mode and the size. It is also screened for register combinations that the instruction format forbids. For a word load whose destination is the program counter, the block takes the loaded value and either produces a branch target or raises a fault.

Each request is taken in one cycle. Its response appears on the registered outputs on the next clock edge, together with a single-cycle valid pulse.

Top module: `ldst_addr_gen`

## Requirements
- R1: After reset every output is 0. `rsp_valid` is 1 exactly in the cycle after a clock edge at which `req_valid` was 1, and is 0 otherwise.
- R2: Mode code 0 (plain offset) gives `rsp_addr` = base + offset or base − offset, computed modulo 2^32. `rsp_wb_val` carries the same value, and `rsp_wb_en` is 0.
- R3: Mode code 1 (pre-indexed) gives `rsp_addr` = `rsp_wb_val` = base ± offset. `rsp_wb_en` is 1 when no error flag is set.
- R4: Mode code 2 (post-indexed) gives `rsp_addr` = unmodified base and `rsp_wb_val` = base ± offset. `rsp_wb_en` is 1 when no error flag is set.
- R5: Sizes 0 (byte), 1 (halfword) and 2 (word) are single accesses. In mode 0 a single access accepts offsets from −255 to +4095. In modes 1 and 2 it accepts −255 to +255. Any other offset sets `rsp_err_offset`.
- R6: Size 3 (two words) needs an offset magnitude that is a multiple of 4 and no larger than 1020, in every mode; otherwise `rsp_err_offset` is set. `rsp_addr2` always equals `rsp_addr` + 4.
- R7: A two-word load whose destination fields `req_rt` and `req_rt2` are equal sets `rsp_err_encoding`. So does any request in modes 1 or 2 whose base field `req_rn` equals `req_rt`, or, for size 3, equals `req_rt2`.
- R8: Register index 15 is the program counter and 13 is the stack pointer. A store sets `rsp_err_encoding` if its data register (`req_rt`, or `req_rt2` for size 3) is 15, or if `req_rn` is 15. It also does so if its data register is 13 and the size is not 2. A load sets `rsp_err_encoding` if a destination is 13 or 15 and the size is not 2.
- R9: A load of size 2 with `req_rt` = 15 and no offset or encoding error is a program-counter load. If `req_ldval` bit 0 is 1, `rsp_branch` is 1 and `rsp_branch_tgt` is `req_ldval` with bit 0 cleared. If bit 0 is 0, `rsp_pc_fault` is 1 and `rsp_branch` is 0.
- R10: `rsp_wb_en` is 1 only in modes 1 and 2 with none of `rsp_err_offset`, `rsp_err_encoding`, `rsp_pc_fault` set. Mode code 3 sets `rsp_err_encoding`. `rsp_flags_we` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| req_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 two words |
| req_base | input | ADDR_W | Base register value |
| req_imm | input | IMM_W | Offset magnitude |
| req_sub | input | 1 | 1 = subtract offset |
| req_rt | input | RIDX_W | First data register index |
| req_rt2 | input | RIDX_W | Second data register index |
| req_rn | input | RIDX_W | Base register index |
| req_ldval | input | ADDR_W | Loaded value for program-counter loads |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | ADDR_W | Access address |
| rsp_addr2 | output | ADDR_W | Second-word address |
| rsp_wb_val | output | ADDR_W | Base writeback value |
| rsp_wb_en | output | 1 | Base writeback enable |
| rsp_err_offset | output | 1 | Offset out of range |
| rsp_err_encoding | output | 1 | Illegal register or mode combination |
| rsp_pc_fault | output | 1 | Program-counter load with bit 0 clear |
| rsp_branch | output | 1 | Program-counter load branches |
| rsp_branch_tgt | output | ADDR_W | Branch target |
| rsp_flags_we | output | 1 | Condition flag update enable |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 12-bit offset magnitude with limits 4095/255/1020, four-byte pairing and the shared-adder variant. With these values the full immediate range can be driven, including the +4095 limit, the −256 and +256 edges and misaligned two-word offsets. Bases near 2^32 and near 0 reach the wrap in both directions. Indices 13 and 15 are hit by the directed cases and often enough by the random mix that the register rules meet the offset checks in the same request.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

   typedef enum logic [1:0] {
      AM_OFFSET = 2'd0,
      AM_PRE    = 2'd1,
      AM_POST   = 2'd2,
      AM_RSVD   = 2'd3
   } am_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DUAL = 2'd3
   } acc_size_e;

   function automatic logic is_indexed(input logic [1:0] mode);
      return (mode == AM_PRE) || (mode == AM_POST);
   endfunction

endpackage

// File: rtl/ldst_agu_arith.sv
module ldst_agu_arith #(
   parameter int ADDR_W       = 32,
   parameter int IMM_W        = 12,
   parameter int STEP         = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic              sub,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr2,
   output logic [ADDR_W-1:0] moved
);
   import ldst_agu_pkg::*;

   localparam int PAD_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] ext;
   assign ext = {{PAD_W{1'b0}}, imm};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] operand;
         always_comb begin
            operand = sub ? ~ext : ext;
            moved   = base + operand + {{(ADDR_W-1){1'b0}}, sub};
         end
      end else begin : g_split
         logic [ADDR_W-1:0] sum_up;
         logic [ADDR_W-1:0] sum_dn;
         always_comb begin
            sum_up = base + ext;
            sum_dn = base - ext;
            moved  = sub ? sum_dn : sum_up;
         end
      end
   endgenerate

   always_comb begin
      addr  = (mode == AM_POST) ? base : moved;
      addr2 = addr + ADDR_W'(STEP);
   end

endmodule

// File: rtl/ldst_agu_range.sv
module ldst_agu_range #(
   parameter int IMM_W         = 12,
   parameter int IMM_POS_LIMIT = 4095,
   parameter int IDX_LIMIT     = 255,
   parameter int NEG_LIMIT     = 255,
   parameter int DUAL_LIMIT    = 1020,
   parameter int DUAL_ALIGN    = 4
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             sub,
   input  logic [1:0]       mode,
   input  logic [1:0]       size,
   output logic             bad
);
   import ldst_agu_pkg::*;

   localparam int ALIGN_BITS = $clog2(DUAL_ALIGN);
   localparam logic [IMM_W-1:0] POS_LIM  = IMM_W'(IMM_POS_LIMIT);
   localparam logic [IMM_W-1:0] IDX_LIM  = IMM_W'(IDX_LIMIT);
   localparam logic [IMM_W-1:0] NEG_LIM  = IMM_W'(NEG_LIMIT);
   localparam logic [IMM_W-1:0] DUAL_LIM = IMM_W'(DUAL_LIMIT);

   logic misaligned;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign misaligned = 1'b0;
      end else begin : g_align
         assign misaligned = |imm[ALIGN_BITS-1:0];
      end
   endgenerate

   logic over_single;
   logic over_dual;

   always_comb begin
      if (sub)
         over_single = imm > NEG_LIM;
      else if (mode == AM_OFFSET)
         over_single = imm > POS_LIM;
      else
         over_single = imm > IDX_LIM;
      over_dual = misaligned || (imm > DUAL_LIM);
      bad = (size == SZ_DUAL) ? over_dual : over_single;
   end

endmodule

// File: rtl/ldst_agu_regchk.sv
module ldst_agu_regchk #(
   parameter int RIDX_W = 4,
   parameter int PC_IDX = 15,
   parameter int SP_IDX = 13
) (
   input  logic              load,
   input  logic [1:0]        mode,
   input  logic [1:0]        size,
   input  logic [RIDX_W-1:0] rt,
   input  logic [RIDX_W-1:0] rt2,
   input  logic [RIDX_W-1:0] rn,
   output logic              bad
);
   import ldst_agu_pkg::*;

   localparam logic [RIDX_W-1:0] PC_R = RIDX_W'(PC_IDX);
   localparam logic [RIDX_W-1:0] SP_R = RIDX_W'(SP_IDX);

   logic dual, word, idx;
   logic rt_pc, rt_sp, rt2_pc, rt2_sp;
   logic pair_clash, base_clash, load_bad, store_bad;

   always_comb begin
      dual   = (size == SZ_DUAL);
      word   = (size == SZ_WORD);
      idx    = is_indexed(mode);
      rt_pc  = (rt == PC_R);
      rt_sp  = (rt == SP_R);
      rt2_pc = dual && (rt2 == PC_R);
      rt2_sp = dual && (rt2 == SP_R);

      pair_clash = load && dual && (rt == rt2);
      base_clash = idx && ((rn == rt) || (dual && (rn == rt2)));
      load_bad   = load && !word && (rt_pc || rt_sp || rt2_pc || rt2_sp);
      store_bad  = !load && (rt_pc || rt2_pc || (rn == PC_R) ||
                             (!word && (rt_sp || rt2_sp)));

      bad = (mode == AM_RSVD) || pair_clash || base_clash || load_bad || store_bad;
   end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
   parameter int ADDR_W        = 32,
   parameter int RIDX_W        = 4,
   parameter int PC_IDX        = 15,
   parameter int SP_IDX        = 13,
   parameter int IMM_POS_LIMIT = 4095,
   parameter int IDX_LIMIT     = 255,
   parameter int NEG_LIMIT     = 255,
   parameter int DUAL_LIMIT    = 1020,
   parameter int DUAL_ALIGN    = 4,
   parameter bit SHARED_ADDER  = 1'b1,
   localparam int IMM_W        = $clog2(IMM_POS_LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_load,
   input  logic [1:0]        req_mode,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [IMM_W-1:0]  req_imm,
   input  logic              req_sub,
   input  logic [RIDX_W-1:0] req_rt,
   input  logic [RIDX_W-1:0] req_rt2,
   input  logic [RIDX_W-1:0] req_rn,
   input  logic [ADDR_W-1:0] req_ldval,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [ADDR_W-1:0] rsp_addr2,
   output logic [ADDR_W-1:0] rsp_wb_val,
   output logic              rsp_wb_en,
   output logic              rsp_err_offset,
   output logic              rsp_err_encoding,
   output logic              rsp_pc_fault,
   output logic              rsp_branch,
   output logic [ADDR_W-1:0] rsp_branch_tgt,
   output logic              rsp_flags_we
);
   import ldst_agu_pkg::*;

   localparam int STEP = ADDR_W / 8;

   generate
      if (ADDR_W <= IMM_W || (ADDR_W % 8) != 0) begin : g_bad_addr_w
         initial $fatal(1, "ldst_addr_gen: ADDR_W must be a byte multiple wider than the offset");
      end
      if (IDX_LIMIT > IMM_POS_LIMIT || NEG_LIMIT > IMM_POS_LIMIT || DUAL_LIMIT > IMM_POS_LIMIT) begin : g_bad_lim
         initial $fatal(1, "ldst_addr_gen: range limits exceed the offset field");
      end
      if (DUAL_ALIGN < 1 || (DUAL_ALIGN & (DUAL_ALIGN - 1)) != 0) begin : g_bad_align
         initial $fatal(1, "ldst_addr_gen: DUAL_ALIGN must be a power of two");
      end
      if (PC_IDX >= (1 << RIDX_W) || SP_IDX >= (1 << RIDX_W) || PC_IDX == SP_IDX) begin : g_bad_idx
         initial $fatal(1, "ldst_addr_gen: special register indices invalid");
      end
   endgenerate

   logic [ADDR_W-1:0] c_addr, c_addr2, c_moved;
   logic              c_off_bad, c_enc_bad;

   ldst_agu_arith #(
      .ADDR_W(ADDR_W), .IMM_W(IMM_W), .STEP(STEP), .SHARED_ADDER(SHARED_ADDER)
   ) u_arith (
      .base(req_base), .imm(req_imm), .sub(req_sub), .mode(req_mode),
      .addr(c_addr), .addr2(c_addr2), .moved(c_moved)
   );

   ldst_agu_range #(
      .IMM_W(IMM_W), .IMM_POS_LIMIT(IMM_POS_LIMIT), .IDX_LIMIT(IDX_LIMIT),
      .NEG_LIMIT(NEG_LIMIT), .DUAL_LIMIT(DUAL_LIMIT), .DUAL_ALIGN(DUAL_ALIGN)
   ) u_range (
      .imm(req_imm), .sub(req_sub), .mode(req_mode), .size(req_size), .bad(c_off_bad)
   );

   ldst_agu_regchk #(
      .RIDX_W(RIDX_W), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX)
   ) u_regchk (
      .load(req_load), .mode(req_mode), .size(req_size),
      .rt(req_rt), .rt2(req_rt2), .rn(req_rn), .bad(c_enc_bad)
   );

   logic c_pc_load, c_branch, c_fault, c_wb_en;
   logic [ADDR_W-1:0] c_tgt;

   always_comb begin
      c_pc_load = req_load && (req_size == SZ_WORD) &&
                  (req_rt == RIDX_W'(PC_IDX)) && !c_off_bad && !c_enc_bad;
      c_branch  = c_pc_load && req_ldval[0];
      c_fault   = c_pc_load && !req_ldval[0];
      c_tgt     = {req_ldval[ADDR_W-1:1], 1'b0};
      c_wb_en   = is_indexed(req_mode) && !c_off_bad && !c_enc_bad && !c_fault;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid        <= 1'b0;
         rsp_addr         <= '0;
         rsp_addr2        <= '0;
         rsp_wb_val       <= '0;
         rsp_wb_en        <= 1'b0;
         rsp_err_offset   <= 1'b0;
         rsp_err_encoding <= 1'b0;
         rsp_pc_fault     <= 1'b0;
         rsp_branch       <= 1'b0;
         rsp_branch_tgt   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr         <= c_addr;
            rsp_addr2        <= c_addr2;
            rsp_wb_val       <= c_moved;
            rsp_wb_en        <= c_wb_en;
            rsp_err_offset   <= c_off_bad;
            rsp_err_encoding <= c_enc_bad;
            rsp_pc_fault     <= c_fault;
            rsp_branch       <= c_branch;
            rsp_branch_tgt   <= c_tgt;
         end
      end
   end

   assign rsp_flags_we = 1'b0;

endmodule

// File: rtl/ldst_addr_gen_chk.sv
module ldst_addr_gen_chk #(
   parameter int ADDR_W     = 32,
   parameter int IMM_W      = 12,
   parameter int DUAL_ALIGN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_mode,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_base,
   input logic [IMM_W-1:0]  req_imm,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [ADDR_W-1:0] rsp_addr2,
   input logic              rsp_wb_en,
   input logic              rsp_err_offset,
   input logic              rsp_err_encoding,
   input logic              rsp_pc_fault,
   input logic              rsp_branch,
   input logic [ADDR_W-1:0] rsp_branch_tgt
);
   localparam int STEP = ADDR_W / 8;

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R4
   post_addr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd2) |=> (rsp_addr == $past(req_base)));

   // R6
   pair_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_addr2 == rsp_addr + ADDR_W'(STEP)));

   // R6
   pair_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3 && (int'(req_imm) % DUAL_ALIGN) != 0) |=> rsp_err_offset);

   // R10
   wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wb_en |-> (!rsp_err_offset && !rsp_err_encoding && !rsp_pc_fault));

   // R9
   branch_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_branch |-> (!rsp_pc_fault && !rsp_branch_tgt[0]));

endmodule

bind ldst_addr_gen ldst_addr_gen_chk #(
   .ADDR_W(ADDR_W), .IMM_W(IMM_W), .DUAL_ALIGN(DUAL_ALIGN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .req_size(req_size), .req_base(req_base), .req_imm(req_imm),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_addr2(rsp_addr2),
   .rsp_wb_en(rsp_wb_en), .rsp_err_offset(rsp_err_offset),
   .rsp_err_encoding(rsp_err_encoding), .rsp_pc_fault(rsp_pc_fault),
   .rsp_branch(rsp_branch), .rsp_branch_tgt(rsp_branch_tgt)
);

// File: tb/ldst_addr_gen_tb.sv
module ldst_addr_gen_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        req_valid = 1'b0, req_load = 1'b0, req_sub = 1'b0;
   logic [1:0]  req_mode = '0, req_size = '0;
   logic [31:0] req_base = '0, req_ldval = '0;
   logic [11:0] req_imm = '0;
   logic [3:0]  req_rt = '0, req_rt2 = '0, req_rn = '0;

   logic        rsp_valid, rsp_wb_en, rsp_err_offset, rsp_err_encoding;
   logic        rsp_pc_fault, rsp_branch, rsp_flags_we;
   logic [31:0] rsp_addr, rsp_addr2, rsp_wb_val, rsp_branch_tgt;

   ldst_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
      .req_mode(req_mode), .req_size(req_size), .req_base(req_base),
      .req_imm(req_imm), .req_sub(req_sub), .req_rt(req_rt), .req_rt2(req_rt2),
      .req_rn(req_rn), .req_ldval(req_ldval), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_addr2(rsp_addr2), .rsp_wb_val(rsp_wb_val),
      .rsp_wb_en(rsp_wb_en), .rsp_err_offset(rsp_err_offset),
      .rsp_err_encoding(rsp_err_encoding), .rsp_pc_fault(rsp_pc_fault),
      .rsp_branch(rsp_branch), .rsp_branch_tgt(rsp_branch_tgt),
      .rsp_flags_we(rsp_flags_we)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      bit          valid;
      logic [31:0] addr, addr2, wb_val, tgt;
      bit          wb_en, eoff, eenc, fault, br;
      string       tag;
   } exp_t;

   exp_t q[$];

   function automatic exp_t model(bit v, bit ld, int mode, int size, logic [31:0] base,
                                  int imm, bit sub, int rt, int rt2, int rn,
                                  logic [31:0] ldv, string tag);
      exp_t e;
      bit idx, dual, word, pcl;
      logic [31:0] moved;
      e.valid = v;
      e.tag   = tag;
      idx  = (mode == 1) || (mode == 2);
      dual = (size == 3);
      word = (size == 2);
      moved = sub ? base - 32'(imm) : base + 32'(imm);
      e.wb_val = moved;
      e.addr   = (mode == 2) ? base : moved;
      e.addr2  = e.addr + 32'd4;
      if (dual)
         e.eoff = (imm % 4 != 0) || (imm > 1020);
      else if (sub)
         e.eoff = imm > 255;
      else if (mode == 0)
         e.eoff = imm > 4095;
      else
         e.eoff = imm > 255;
      e.eenc = (mode == 3);
      if (ld && dual && rt == rt2) e.eenc = 1;
      if (idx && (rn == rt || (dual && rn == rt2))) e.eenc = 1;
      if (ld && !word && (rt == 15 || rt == 13 || (dual && (rt2 == 15 || rt2 == 13)))) e.eenc = 1;
      if (!ld && (rt == 15 || rn == 15 || (dual && rt2 == 15))) e.eenc = 1;
      if (!ld && !word && (rt == 13 || (dual && rt2 == 13))) e.eenc = 1;
      pcl = ld && word && rt == 15 && !e.eoff && !e.eenc;
      e.br    = pcl && ldv[0];
      e.fault = pcl && !ldv[0];
      e.tgt   = ldv & 32'hFFFF_FFFE;
      e.wb_en = idx && !e.eoff && !e.eenc && !e.fault;
      return e;
   endfunction

   task automatic compare(exp_t e);
      n_tests++;
      if (rsp_flags_we !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 flags_we actual=%b expected=0", rsp_flags_we);
      end
      if (rsp_valid !== e.valid) begin
         n_fail++;
         $display("FAIL %s valid actual=%b expected=%b", e.tag, rsp_valid, e.valid);
      end else if (e.valid) begin
         if (rsp_addr !== e.addr || rsp_addr2 !== e.addr2 || rsp_wb_val !== e.wb_val ||
             rsp_wb_en !== e.wb_en || rsp_err_offset !== e.eoff ||
             rsp_err_encoding !== e.eenc || rsp_pc_fault !== e.fault ||
             rsp_branch !== e.br || (e.br && rsp_branch_tgt !== e.tgt)) begin
            n_fail++;
            $display("FAIL %s actual addr=%h a2=%h wb=%h wben=%b eo=%b ee=%b pf=%b br=%b tgt=%h expected addr=%h a2=%h wb=%h wben=%b eo=%b ee=%b pf=%b br=%b tgt=%h",
                     e.tag, rsp_addr, rsp_addr2, rsp_wb_val, rsp_wb_en, rsp_err_offset,
                     rsp_err_encoding, rsp_pc_fault, rsp_branch, rsp_branch_tgt,
                     e.addr, e.addr2, e.wb_val, e.wb_en, e.eoff, e.eenc, e.fault, e.br, e.tgt);
         end
      end
   endtask

   task automatic tick(bit v, bit ld, int mode, int size, logic [31:0] base, int imm,
                       bit sub, int rt, int rt2, int rn, logic [31:0] ldv, string tag);
      @(negedge clk);
      if (q.size() > 0) compare(q.pop_front());
      req_valid = v;
      req_load  = ld;
      req_mode  = 2'(mode);
      req_size  = 2'(size);
      req_base  = base;
      req_imm   = 12'(imm);
      req_sub   = sub;
      req_rt    = 4'(rt);
      req_rt2   = 4'(rt2);
      req_rn    = 4'(rn);
      req_ldval = ldv;
      q.push_back(model(v, ld, mode, size, base, imm, sub, rt, rt2, rn, ldv, tag));
   endtask

   task automatic idle(string tag);
      tick(0, 0, 0, 0, 32'h0, 0, 0, 1, 2, 3, 32'h0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      n_tests++;
      if (rsp_valid !== 0 || rsp_addr !== 0 || rsp_wb_en !== 0 || rsp_err_offset !== 0 ||
          rsp_err_encoding !== 0 || rsp_branch !== 0 || rsp_pc_fault !== 0) begin
         n_fail++;
         $display("FAIL R1 reset actual valid=%b addr=%h expected 0 0", rsp_valid, rsp_addr);
      end
      rst_n = 1'b1;
      idle("R1");
      // R2 plain offset, add/sub and wrap
      tick(1, 1, 0, 2, 32'h0000_1000, 4095, 0, 1, 2, 3, 0, "R2");
      tick(1, 0, 0, 0, 32'h0000_0010, 255, 1, 1, 2, 3, 0, "R2");
      tick(1, 1, 0, 1, 32'hFFFF_FFF0, 32, 0, 1, 2, 3, 0, "R2");
      idle("R1");
      // R3 pre-indexed
      tick(1, 1, 1, 2, 32'h2000_0000, 255, 0, 1, 2, 3, 0, "R3");
      tick(1, 0, 1, 0, 32'h0000_0004, 8, 1, 1, 2, 3, 0, "R3");
      // R4 post-indexed
      tick(1, 1, 2, 2, 32'h3000_0000, 100, 0, 1, 2, 3, 0, "R4");
      tick(1, 0, 2, 1, 32'h3000_0000, 255, 1, 1, 2, 3, 0, "R4");
      // R5 range edges
      tick(1, 1, 0, 0, 32'h1000, 256, 1, 1, 2, 3, 0, "R5");
      tick(1, 1, 1, 0, 32'h1000, 256, 0, 1, 2, 3, 0, "R5");
      tick(1, 1, 2, 2, 32'h1000, 256, 1, 1, 2, 3, 0, "R5");
      tick(1, 1, 0, 1, 32'h1000, 256, 0, 1, 2, 3, 0, "R5");
      // R6 two-word
      tick(1, 1, 0, 3, 32'h4000, 1020, 0, 1, 2, 3, 0, "R6");
      tick(1, 1, 1, 3, 32'h4000, 1024, 1, 1, 2, 3, 0, "R6");
      tick(1, 0, 2, 3, 32'h4000, 6, 0, 1, 2, 3, 0, "R6");
      tick(1, 1, 0, 3, 32'h4000, 1020, 1, 1, 2, 3, 0, "R6");
      // R7 register clashes
      tick(1, 1, 0, 3, 32'h5000, 8, 0, 4, 4, 3, 0, "R7");
      tick(1, 0, 1, 2, 32'h5000, 8, 0, 3, 2, 3, 0, "R7");
      tick(1, 1, 2, 3, 32'h5000, 8, 0, 1, 3, 3, 0, "R7");
      tick(1, 0, 0, 2, 32'h5000, 8, 0, 3, 2, 3, 0, "R7");
      // R8 special registers
      tick(1, 0, 0, 2, 32'h6000, 4, 0, 15, 2, 3, 0, "R8");
      tick(1, 0, 0, 2, 32'h6000, 4, 0, 1, 2, 15, 0, "R8");
      tick(1, 0, 0, 2, 32'h6000, 4, 0, 13, 2, 3, 0, "R8");
      tick(1, 0, 0, 0, 32'h6000, 4, 0, 13, 2, 3, 0, "R8");
      tick(1, 1, 0, 1, 32'h6000, 4, 0, 15, 2, 3, 0, "R8");
      tick(1, 1, 0, 2, 32'h6000, 4, 0, 13, 2, 15, 0, "R8");
      // R9 program-counter load
      tick(1, 1, 0, 2, 32'h7000, 4, 0, 15, 2, 3, 32'h0800_0101, "R9");
      tick(1, 1, 1, 2, 32'h7000, 4, 0, 15, 2, 3, 32'h0800_0100, "R9");
      tick(1, 1, 0, 2, 32'h7000, 300, 1, 15, 2, 3, 32'h0800_0100, "R9");
      // R10 reserved mode and writeback gating
      tick(1, 1, 3, 2, 32'h8000, 4, 0, 1, 2, 3, 0, "R10");
      tick(1, 1, 1, 3, 32'h8000, 3, 0, 1, 2, 3, 0, "R10");
      idle("R1");
      idle("R1");
      // R2 mixed random traffic
      for (int i = 0; i < 600; i++) begin
         int imm;
         imm = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 4095))
                                            : int'($urandom_range(0, 300));
         tick($urandom_range(0, 4) != 0, 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), $urandom(),
              imm, 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), $urandom(), "R2");
      end
      idle("R1");
      idle("R1");
      finish_run();
   end

endmodule